// File: doc/BRIEF.md
# Link Power-Status Monitor

This block watches the power-status signal that a link-layer controller drives towards the PHY and sets the state of the PHY-to-link interface from it. The status signal may be a steady level or a pulse train, as it is when it crosses an isolation barrier. Only a low run that is long enough counts as a loss of the link. Short low gaps between pulses are tolerated. A low run past a first limit moves the interface into a low-power reset state. A much longer run moves it into a low-power disabled state.

In the reset state the control and data lines towards the link are forced to zero and the link's request line is masked, but the PHY clock keeps running. In the disabled state the clock enable is also dropped. When the status signal is seen high again the interface returns to active at once. On a return from disabled the clock is enabled first, and the control and data lines stay forced for a few more cycles so the link sees a running clock before any data. The block also produces the link-active bit for the self-identification packet. That bit combines the interface state with a link-control register bit.

Top module: `link_pwr_monitor`

## Requirements
- R1: After reset the state code `iface_state` is 0 (active), `pclk_en` is 1 and `ctl_out`, `data_out` and `lreq_out` pass `ctl_in`, `data_in` and `lreq_in` unchanged.
- R2: `lps_async` passes through a two-flop synchronizer. A change on it takes effect on `iface_state` at the third rising clock edge after the change.
- R3: The state goes to 1 (low-power reset) on the (RST_LIMIT+1)th consecutive low synchronized sample. A low run of exactly RST_LIMIT samples leaves the state at 0.
- R4: While the state is 1, `ctl_out`, `data_out` and `lreq_out` are 0 whatever the inputs are, and `pclk_en` stays 1.
- R5: The state goes to 2 (low-power disabled) on the (DIS_LIMIT+1)th consecutive low sample. A run of exactly DIS_LIMIT samples never reaches 2. In state 2, `pclk_en` is 0 and the outputs are forced to 0.
- R6: Any high synchronized sample clears the low-run count. A pulse train whose low runs are at most RST_LIMIT samples, with high gaps of one cycle, keeps the state at 0.
- R7: The low-run counter saturates at DIS_LIMIT, so an arbitrarily long low run keeps the state at 2.
- R8: On a return from state 1 to state 0, the outputs pass their inputs in the same cycle that the state becomes 0.
- R9: On a return from state 2, `pclk_en` rises in the same cycle that the state becomes 0. The outputs stay forced to 0 for WAKE_CYCLES further cycles and are then released.
- R10: `link_active` is 1 only when `link_ctl_en` is 1 and the state is 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lps_async | input | 1 | Link power-status signal, level or pulse train, asynchronous |
| link_ctl_en | input | 1 | Link-control register bit |
| lreq_in | input | 1 | Request line from the link |
| ctl_in | input | CTL_W | Control bits from the PHY core towards the link |
| data_in | input | DATA_W | Data bits from the PHY core towards the link |
| lreq_out | output | 1 | Request line passed to the PHY core, masked when not active |
| ctl_out | output | CTL_W | Control bits to the link, forced to 0 in low power |
| data_out | output | DATA_W | Data bits to the link, forced to 0 in low power |
| pclk_en | output | 1 | Enable for the PHY clock towards the link |
| link_active | output | 1 | Link-active bit for self-identification |
| iface_state | output | 2 | Interface state: 0 active, 1 low-power reset, 2 low-power disabled |

## Verification
The bench drives low runs of exactly RST_LIMIT and DIS_LIMIT samples and runs one sample longer. A design with an off-by-one threshold would enter low power too early or too late at these lengths. A pulse train with one-cycle high gaps shows whether the low count is cleared by a single high sample; a design that only decays the count would drift into reset. The wake from disabled is checked cycle by cycle. A design that releases data together with the clock, or that holds the clock off one cycle too long, shows up as a miscompare at the exact edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        LP_ACTIVE   = 2'd0,
        LP_RESET    = 2'd1,
        LP_DISABLED = 2'd2
    } lp_state_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_comb sync_d[i] = sync_q[i-1];
    end

    // Reset to high so that no low run is counted straight after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign d_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
    parameter int RST_LIMIT = 256,
    parameter int DIS_LIMIT = 2560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic past_rst,
    output logic past_dis
);
    localparam int CW = $clog2(DIS_LIMIT + 1);
    localparam logic [CW-1:0] RST_L = CW'(RST_LIMIT);
    localparam logic [CW-1:0] DIS_L = CW'(DIS_LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (level)                 r_d.cnt = '0;
        else if (r_q.cnt < DIS_L)  r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign past_rst = (r_q.cnt >= RST_L);
    assign past_dis = (r_q.cnt >= DIS_L);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= DIS_L);

    // R6
    high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level |=> (r_q.cnt == '0));
endmodule

// File: rtl/lpm_state_ctrl.sv
module lpm_state_ctrl
    import lpm_pkg::*;
#(
    parameter int WAKE_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  logic      past_rst,
    input  logic      past_dis,
    output lp_state_e state,
    output logic      force_low,
    output logic      clk_on
);
    localparam int HW = $clog2(WAKE_CYCLES + 2);
    localparam logic [HW-1:0] WAKE_L = HW'(WAKE_CYCLES);

    typedef struct packed {
        lp_state_e     st;
        logic [HW-1:0] hold;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (c_q.hold != '0) c_d.hold = c_q.hold - 1'b1;
        if (level) begin
            c_d.st = LP_ACTIVE;
            if (c_q.st == LP_DISABLED) c_d.hold = WAKE_L;
        end else if (past_dis) begin
            c_d.st = LP_DISABLED;
        end else if (past_rst) begin
            c_d.st = LP_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: LP_ACTIVE, hold: '0};
        else        c_q <= c_d;
    end

    assign state     = c_q.st;
    assign clk_on    = (c_q.st != LP_DISABLED);
    assign force_low = (c_q.st != LP_ACTIVE) || (c_q.hold != '0);

    // R6
    high_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level |=> (c_q.st == LP_ACTIVE));

    // R5
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == LP_ACTIVE) |=> (c_q.st != LP_DISABLED));
endmodule

// File: rtl/link_pwr_monitor.sv
module link_pwr_monitor
    import lpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_LIMIT   = 256,
    parameter int DIS_LIMIT   = 2560,
    parameter int WAKE_CYCLES = 4,
    parameter int CTL_W       = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lps_async,
    input  logic              link_ctl_en,
    input  logic              lreq_in,
    input  logic [CTL_W-1:0]  ctl_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              lreq_out,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [DATA_W-1:0] data_out,
    output logic              pclk_en,
    output logic              link_active,
    output logic [1:0]        iface_state
);
    logic      lvl_sync;
    logic      past_rst, past_dis;
    logic      force_low, clk_on;
    lp_state_e st;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lps_async),
        .d_sync  (lvl_sync)
    );

    lpm_low_timer #(.RST_LIMIT(RST_LIMIT), .DIS_LIMIT(DIS_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl_sync),
        .past_rst (past_rst),
        .past_dis (past_dis)
    );

    lpm_state_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (lvl_sync),
        .past_rst  (past_rst),
        .past_dis  (past_dis),
        .state     (st),
        .force_low (force_low),
        .clk_on    (clk_on)
    );

    assign ctl_out     = force_low ? '0 : ctl_in;
    assign data_out    = force_low ? '0 : data_in;
    assign lreq_out    = force_low ? 1'b0 : lreq_in;
    assign pclk_en     = clk_on;
    assign link_active = link_ctl_en && (st == LP_ACTIVE);
    assign iface_state = st;

    // R4
    lowpwr_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iface_state != 2'd0) |-> (ctl_out == '0 && data_out == '0 && !lreq_out));

    // R9
    clk_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pclk_en) |-> (data_out == '0 && ctl_out == '0));

    // R10
    link_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_active |-> (iface_state == 2'd0 && link_ctl_en));
endmodule

// File: tb/link_pwr_monitor_bench.sv
module link_pwr_monitor_bench;
    localparam int RST  = 256;
    localparam int DIS  = 2560;
    localparam int WAKE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lps = 1'b1;
    logic       lctl = 1'b1;
    logic       lreq_in = 1'b1;
    logic [1:0] ctl_in = 2'b11;
    logic [7:0] data_in = 8'hA5;
    logic       lreq_out, pclk_en, link_active;
    logic [1:0] ctl_out, iface_state;
    logic [7:0] data_out;

    int n_chk = 0;
    int n_fail = 0;
    logic seen_rst = 1'b0;
    logic seen_dis = 1'b0;

    always #10 clk = ~clk;

    link_pwr_monitor #(
        .SYNC_STAGES(2), .RST_LIMIT(RST), .DIS_LIMIT(DIS),
        .WAKE_CYCLES(WAKE), .CTL_W(2), .DATA_W(8)
    ) u_link_pwr_monitor (
        .clk(clk), .rst_n(rst_n), .lps_async(lps), .link_ctl_en(lctl),
        .lreq_in(lreq_in), .ctl_in(ctl_in), .data_in(data_in),
        .lreq_out(lreq_out), .ctl_out(ctl_out), .data_out(data_out),
        .pclk_en(pclk_en), .link_active(link_active), .iface_state(iface_state)
    );

    always @(posedge clk) begin
        if (iface_state == 2'd1) seen_rst <= 1'b1;
        if (iface_state == 2'd2) seen_dis <= 1'b1;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_passed(input string req);
        chk({req, " data"}, int'(data_out), int'(data_in));
        chk({req, " ctl"},  int'(ctl_out),  int'(ctl_in));
        chk({req, " lreq"}, int'(lreq_out), int'(lreq_in));
    endtask

    task automatic chk_forced(input string req);
        chk({req, " data"}, int'(data_out), 0);
        chk({req, " ctl"},  int'(ctl_out),  0);
        chk({req, " lreq"}, int'(lreq_out), 0);
    endtask

    task automatic t_reset_state;
        chk("R1 state", int'(iface_state), 0);
        chk("R1 pclk_en", int'(pclk_en), 1);
        chk_passed("R1");
    endtask

    task automatic t_enter_reset;
        lps = 1'b0;
        step(RST + 2);
        chk("R3 boundary state", int'(iface_state), 0);
        chk_passed("R3 boundary");
        step(1);
        chk("R3 state", int'(iface_state), 1);
        chk_forced("R4");
        chk("R4 pclk_en", int'(pclk_en), 1);
        chk("R10 link_active in reset", int'(link_active), 0);
        lps = 1'b1;
        step(2);
        chk("R2 latency", int'(iface_state), 1);
        step(1);
        chk("R2 wake", int'(iface_state), 0);
        chk_passed("R8");
    endtask

    task automatic t_short_run;
        seen_rst = 1'b0;
        lps = 1'b0;
        step(RST);
        lps = 1'b1;
        step(5);
        chk("R3 run of RST_LIMIT", int'(seen_rst), 0);
    endtask

    task automatic t_pulse_train;
        seen_rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            lps = 1'b0;
            step(RST);
            lps = 1'b1;
            step(1);
        end
        step(4);
        chk("R6 pulse train", int'(seen_rst), 0);
        chk("R6 state", int'(iface_state), 0);
    endtask

    task automatic t_dis_boundary;
        seen_rst = 1'b0;
        seen_dis = 1'b0;
        lps = 1'b0;
        step(DIS);
        lps = 1'b1;
        step(6);
        chk("R5 run of DIS_LIMIT reaches reset", int'(seen_rst), 1);
        chk("R5 run of DIS_LIMIT not disabled", int'(seen_dis), 0);
        chk("R5 back active", int'(iface_state), 0);
    endtask

    task automatic t_disable_wake;
        lps = 1'b0;
        step(DIS + 2);
        chk("R5 before limit", int'(iface_state), 1);
        chk("R5 pclk before limit", int'(pclk_en), 1);
        step(1);
        chk("R5 state", int'(iface_state), 2);
        chk("R5 pclk_en", int'(pclk_en), 0);
        chk_forced("R5");
        step(3000);
        chk("R7 saturate state", int'(iface_state), 2);
        lps = 1'b1;
        step(2);
        chk("R9 still disabled", int'(pclk_en), 0);
        step(1);
        chk("R9 state", int'(iface_state), 0);
        chk("R9 pclk_en", int'(pclk_en), 1);
        chk_forced("R9 hold first");
        step(WAKE - 1);
        chk_forced("R9 hold last");
        step(1);
        chk_passed("R9 release");
    endtask

    task automatic t_link_bit;
        lctl = 1'b1;
        step(1);
        chk("R10 set", int'(link_active), 1);
        lctl = 1'b0;
        step(1);
        chk("R10 clear", int'(link_active), 0);
        lctl = 1'b1;
        data_in = 8'h3C;
        ctl_in = 2'b01;
        lreq_in = 1'b0;
        step(1);
        chk_passed("R1 other pattern");
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset_state();
        t_enter_reset();
        t_short_run();
        t_pulse_train();
        t_dis_boundary();
        t_disable_wake();
        t_link_bit();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule